// File: doc/BRIEF.md
# Virtual Alias Guard for a Virtually Indexed, Physically Tagged L1

This block keeps a virtually indexed, physically tagged L1 cache from holding two copies of one physical line. The L1 set index is taken from the virtual address before translation. When the cache is larger than a page times its associativity, some set-index bits sit above the page offset. These bits can differ between two virtual addresses that map to the same physical line. The block keeps a small directory indexed by physical line address. Each entry records which physical line is resident and the untranslated index bits ("alias bits") it was filled under.

After a miss has been translated, the L1 presents the physical and virtual addresses. The block compares the request against the directory entry. It then does one of two things. It may grant the fill at once. Or it first asks the L1 to purge an older copy and waits for the acknowledge before it grants the fill. An older copy needs purging in two cases. The first is the same line held under other alias bits. The second is another line that holds the same directory slot, which inclusion forces out. The L1 also reports its own evictions so the directory forgets lines that have left.

With the default geometry there are 3 alias bits (cache 2^16 bytes, page 2^12, two ways, 64-byte lines), a 9-bit set index and a 256-entry directory. The directory index width must be at least the number of line-index bits inside the page.

Top module: `vipt_alias_guard`

## Requirements
- R1: After reset, miss_ready is 1 and purge_req and fill_ok are 0. The directory is empty, so the first miss to any line gets no purge.
- R2: A miss is accepted on a clock edge where miss_valid and miss_ready are both 1. If no purge is needed, fill_ok is 1 for exactly the one cycle after acceptance, with purge_req held at 0.
- R3: A miss to a resident line whose alias bits (miss_va[14:12]) equal the stored ones causes no purge. The stored entry is left unchanged.
- R4: A miss to a resident line with different alias bits raises purge_req in the cycle after acceptance. purge_index is {old alias bits in [8:6], miss_pa[11:6] in [5:0]}, and purge_line is miss_pa[31:6].
- R5: purge_req, purge_index and purge_line hold steady until purge_ack is sampled 1. fill_ok rises in the cycle after that edge and is never 1 while purge_req is 1.
- R6: After a fill, the directory holds the new alias bits. A later miss with those bits causes no purge, and a miss with the earlier bits causes a purge.
- R7: A miss whose line shares directory slot miss_pa[13:6] with a different resident line purges that resident line. purge_line is the old line address and purge_index is {its alias bits, miss_pa[11:6]}.
- R8: evict_valid with evict_line equal to the resident line address clears the entry, so the next miss to that line gets no purge whatever its alias bits.
- R9: evict_valid with a line address whose upper bits differ from the resident line in that slot is ignored.
- R10: miss_ready is 0 from the cycle after acceptance through the fill_ok cycle. miss_valid in that window is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| miss_valid | input | 1 | Translated L1 miss presented |
| miss_pa | input | 32 | Physical address of the miss |
| miss_va | input | 32 | Virtual address of the miss |
| miss_ready | output | 1 | Block idle, miss can be accepted |
| purge_req | output | 1 | Request to L1 to drop an older copy |
| purge_index | output | 9 | L1 set index of the copy to drop |
| purge_line | output | 26 | Physical line address of the copy to drop |
| purge_ack | input | 1 | L1 has dropped the copy |
| fill_ok | output | 1 | One-cycle grant for the L1 fill |
| evict_valid | input | 1 | L1 reports a line leaving the cache |
| evict_line | input | 26 | Physical line address of the leaving line |

## Verification
A stale or wrong directory entry shows up at the next miss to that slot, one cycle after acceptance. It appears as a purge that should not happen, a missing purge, or a purge with the wrong set index or line address. A lost eviction or a lost directory update therefore stays invisible until the same slot is touched again. For that reason the stimulus revisits each line under old and new alias bits after every purge and every eviction. A handshake fault shows within one cycle: fill_ok arriving without the acknowledge, or a purge request dropping early.

// File: rtl/vad_pkg.sv
package vad_pkg;

    // Outcome of comparing a request with its directory slot
    typedef enum logic [1:0] {
        DEC_EMPTY  = 2'd0,   // slot free: fill and record
        DEC_MATCH  = 2'd1,   // same line, same alias bits: nothing to do
        DEC_ALIAS  = 2'd2,   // same line, other alias bits: purge old copy
        DEC_VICTIM = 2'd3    // other line in slot: purge it for inclusion
    } vad_dec_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PURGE = 2'd1,
        ST_FILL  = 2'd2
    } vad_state_e;

    function automatic int alias_width(input int c, input int p, input int a);
        return (c > p + a) ? (c - p - a) : 1;
    endfunction

    function automatic logic needs_purge(input vad_dec_e d);
        return (d == DEC_ALIAS) || (d == DEC_VICTIM);
    endfunction

    function automatic logic writes_dir(input vad_dec_e d);
        return d != DEC_MATCH;
    endfunction

endpackage

// File: rtl/vad_directory.sv
module vad_directory #(
    parameter int IDX_W   = 8,
    parameter int TAG_W   = 18,
    parameter int ALIAS_W = 3,
    localparam int DEPTH  = 1 << IDX_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [IDX_W-1:0]   rd_idx,
    output logic               rd_valid,
    output logic [TAG_W-1:0]   rd_tag,
    output logic [ALIAS_W-1:0] rd_alias,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [TAG_W-1:0]   wr_tag,
    input  logic [ALIAS_W-1:0] wr_alias,
    input  logic               clr_en,
    input  logic [IDX_W-1:0]   clr_idx,
    input  logic [TAG_W-1:0]   clr_tag
);

    logic [DEPTH-1:0]   vld_q;
    logic [TAG_W-1:0]   tag_q   [DEPTH];
    logic [ALIAS_W-1:0] alias_q [DEPTH];

    logic clr_hit;
    // An eviction only removes the line it names; a fill to the same slot wins
    assign clr_hit = clr_en && vld_q[clr_idx] && (tag_q[clr_idx] == clr_tag)
                     && !(wr_en && (wr_idx == clr_idx));

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= '0;
        end else begin
            if (clr_hit)
                vld_q[clr_idx] <= 1'b0;
            if (wr_en)
                vld_q[wr_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_idx]   <= wr_tag;
            alias_q[wr_idx] <= wr_alias;
        end
    end

    assign rd_valid = vld_q[rd_idx];
    assign rd_tag   = tag_q[rd_idx];
    assign rd_alias = alias_q[rd_idx];

    // R6: a recorded fill is visible in the slot on the next cycle
    assert_write_sets_valid_R6: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> vld_q[$past(wr_idx)]);

endmodule

// File: rtl/vad_compare.sv
module vad_compare
    import vad_pkg::*;
#(
    parameter int   TAG_W     = 18,
    parameter int   ALIAS_W   = 3,
    parameter logic USE_ALIAS = 1'b1
) (
    input  logic               slot_valid,
    input  logic [TAG_W-1:0]   slot_tag,
    input  logic [ALIAS_W-1:0] slot_alias,
    input  logic [TAG_W-1:0]   req_tag,
    input  logic [ALIAS_W-1:0] req_alias,
    output vad_dec_e           dec
);

    logic alias_differs;

    generate
        if (USE_ALIAS) begin : g_alias
            assign alias_differs = (slot_alias != req_alias);
        end else begin : g_no_alias
            logic unused_alias;
            assign unused_alias  = ^{slot_alias, req_alias};
            assign alias_differs = 1'b0;
        end
    endgenerate

    always_comb begin
        if (!slot_valid)
            dec = DEC_EMPTY;
        else if (slot_tag != req_tag)
            dec = DEC_VICTIM;
        else if (alias_differs)
            dec = DEC_ALIAS;
        else
            dec = DEC_MATCH;
    end

endmodule

// File: rtl/vad_ctrl.sv
module vad_ctrl
    import vad_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic miss_valid,
    input  logic need_purge,
    input  logic purge_ack,
    output logic miss_ready,
    output logic accept,
    output logic purge_req,
    output logic fill_ok
);

    vad_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:  if (miss_valid) state_d = need_purge ? ST_PURGE : ST_FILL;
            ST_PURGE: if (purge_ack)  state_d = ST_FILL;
            ST_FILL:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    assign miss_ready = (state_q == ST_IDLE);
    assign accept     = miss_ready && miss_valid;
    assign purge_req  = (state_q == ST_PURGE);
    assign fill_ok    = (state_q == ST_FILL);

    // R5: an outstanding purge is not withdrawn before it is acknowledged
    assert_purge_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (purge_req && !purge_ack) |=> purge_req);

    // R5: the grant follows either an acceptance or an acknowledged purge
    assert_grant_cause_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(fill_ok) |-> ($past(purge_ack) || $past(accept)));

    // R2: the grant lasts one cycle and the block is idle afterwards
    assert_fill_pulse_R2: assert property (@(posedge clk) disable iff (rst)
        fill_ok |=> (!fill_ok && miss_ready));

    // R10: an accepted miss makes the block busy
    assert_busy_R10: assert property (@(posedge clk) disable iff (rst)
        accept |=> !miss_ready);

endmodule

// File: rtl/vipt_alias_guard.sv
module vipt_alias_guard
    import vad_pkg::*;
#(
    parameter int PA_W      = 32,
    parameter int VA_W      = 32,
    parameter int LINE_B    = 6,
    parameter int CACHE_C   = 16,
    parameter int PAGE_P    = 12,
    parameter int ASSOC_A   = 1,
    parameter int DIR_IDX_W = 8,
    localparam int SET_W    = CACHE_C - LINE_B - ASSOC_A,
    localparam int PLINE_W  = PA_W - LINE_B
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               miss_valid,
    input  logic [PA_W-1:0]    miss_pa,
    input  logic [VA_W-1:0]    miss_va,
    output logic               miss_ready,
    output logic               purge_req,
    output logic [SET_W-1:0]   purge_index,
    output logic [PLINE_W-1:0] purge_line,
    input  logic               purge_ack,
    output logic               fill_ok,
    input  logic               evict_valid,
    input  logic [PLINE_W-1:0] evict_line
);

    localparam logic HAS_ALIAS = (CACHE_C > PAGE_P + ASSOC_A);
    localparam int   ALIAS_W   = alias_width(CACHE_C, PAGE_P, ASSOC_A);
    localparam int   TAG_W     = PLINE_W - DIR_IDX_W;
    localparam int   POFF_W    = PAGE_P - LINE_B;

    // Request fields
    logic [PLINE_W-1:0]   req_line;
    logic [DIR_IDX_W-1:0] req_idx;
    logic [TAG_W-1:0]     req_tag;
    logic [ALIAS_W-1:0]   req_alias;
    logic                 unused_addr;

    assign req_line    = miss_pa[PA_W-1:LINE_B];
    assign req_idx     = req_line[DIR_IDX_W-1:0];
    assign req_tag     = req_line[PLINE_W-1:DIR_IDX_W];
    assign unused_addr = ^{miss_va, miss_pa[LINE_B-1:0]};

    // Captured miss
    logic [PLINE_W-1:0] held_line;
    logic [ALIAS_W-1:0] held_alias;
    logic [TAG_W-1:0]   held_old_tag;
    logic [ALIAS_W-1:0] held_old_alias;
    vad_dec_e           held_dec;

    // Directory slot and decision
    logic               slot_valid;
    logic [TAG_W-1:0]   slot_tag;
    logic [ALIAS_W-1:0] slot_alias;
    vad_dec_e           cur_dec;
    logic               accept;
    logic               dir_wr;

    generate
        if (HAS_ALIAS) begin : g_alias_idx
            assign req_alias   = miss_va[CACHE_C-ASSOC_A-1:PAGE_P];
            // old copy sits at its own alias bits over the shared in-page bits
            assign purge_index = {held_old_alias, held_line[POFF_W-1:0]};
        end else begin : g_flat_idx
            assign req_alias   = '0;
            assign purge_index = held_line[SET_W-1:0];
        end
    endgenerate

    vad_directory #(
        .IDX_W   (DIR_IDX_W),
        .TAG_W   (TAG_W),
        .ALIAS_W (ALIAS_W)
    ) u_dir (
        .clk      (clk),
        .rst      (rst),
        .rd_idx   (req_idx),
        .rd_valid (slot_valid),
        .rd_tag   (slot_tag),
        .rd_alias (slot_alias),
        .wr_en    (dir_wr),
        .wr_idx   (held_line[DIR_IDX_W-1:0]),
        .wr_tag   (held_line[PLINE_W-1:DIR_IDX_W]),
        .wr_alias (held_alias),
        .clr_en   (evict_valid),
        .clr_idx  (evict_line[DIR_IDX_W-1:0]),
        .clr_tag  (evict_line[PLINE_W-1:DIR_IDX_W])
    );

    vad_compare #(
        .TAG_W     (TAG_W),
        .ALIAS_W   (ALIAS_W),
        .USE_ALIAS (HAS_ALIAS)
    ) u_cmp (
        .slot_valid (slot_valid),
        .slot_tag   (slot_tag),
        .slot_alias (slot_alias),
        .req_tag    (req_tag),
        .req_alias  (req_alias),
        .dec        (cur_dec)
    );

    vad_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .miss_valid (miss_valid),
        .need_purge (needs_purge(cur_dec)),
        .purge_ack  (purge_ack),
        .miss_ready (miss_ready),
        .accept     (accept),
        .purge_req  (purge_req),
        .fill_ok    (fill_ok)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            held_line      <= '0;
            held_alias     <= '0;
            held_old_tag   <= '0;
            held_old_alias <= '0;
            held_dec       <= DEC_EMPTY;
        end else if (accept) begin
            held_line      <= req_line;
            held_alias     <= req_alias;
            held_old_tag   <= slot_tag;
            held_old_alias <= slot_alias;
            held_dec       <= cur_dec;
        end
    end

    assign purge_line = {held_old_tag, held_line[DIR_IDX_W-1:0]};
    assign dir_wr     = fill_ok && writes_dir(held_dec);

    // R5: purge target stays put while the L1 has not answered
    assert_purge_stable_R5: assert property (@(posedge clk) disable iff (rst)
        (purge_req && !purge_ack) |=> ($stable(purge_index) && $stable(purge_line)));

    // R3: a request matching its slot is granted straight away
    assert_match_no_purge_R3: assert property (@(posedge clk) disable iff (rst)
        (accept && (cur_dec == DEC_MATCH)) |=> (fill_ok && !purge_req));

    // R4: a conflicting request is not granted before the purge
    assert_conflict_purges_R4: assert property (@(posedge clk) disable iff (rst)
        (accept && needs_purge(cur_dec)) |=> (purge_req && !fill_ok));

endmodule

// File: tb/vipt_alias_guard_test.sv
module vipt_alias_guard_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        miss_valid = 1'b0;
    logic [31:0] miss_pa = '0;
    logic [31:0] miss_va = '0;
    logic        miss_ready;
    logic        purge_req;
    logic [8:0]  purge_index;
    logic [25:0] purge_line;
    logic        purge_ack = 1'b0;
    logic        fill_ok;
    logic        evict_valid = 1'b0;
    logic [25:0] evict_line = '0;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    vipt_alias_guard uut (
        .clk (clk), .rst (rst),
        .miss_valid (miss_valid), .miss_pa (miss_pa), .miss_va (miss_va),
        .miss_ready (miss_ready),
        .purge_req (purge_req), .purge_index (purge_index),
        .purge_line (purge_line), .purge_ack (purge_ack),
        .fill_ok (fill_ok),
        .evict_valid (evict_valid), .evict_line (evict_line)
    );

    // {pa[99:68], va[67:36], purge[35], index[34:26], line[25:0]}
    localparam int NV = 7;
    localparam logic [99:0] VEC [NV] = '{
        {32'h0001_2340, 32'h0000_1340, 1'b0, 9'h000, 26'h0000000}, // R2 first fill
        {32'h0001_2340, 32'h0000_1340, 1'b0, 9'h000, 26'h0000000}, // R3 same alias
        {32'h0001_2340, 32'h0000_5340, 1'b1, 9'h04D, 26'h000048D}, // R4 alias 1 -> 5
        {32'h0001_2340, 32'h0000_5340, 1'b0, 9'h000, 26'h0000000}, // R6 new bits kept
        {32'h0001_2340, 32'h0000_1340, 1'b1, 9'h14D, 26'h000048D}, // R6 old bits purge
        {32'h0005_2340, 32'h0000_7340, 1'b1, 9'h04D, 26'h000048D}, // R7 slot victim
        {32'h0001_2340, 32'h0000_3340, 1'b1, 9'h1CD, 26'h000148D}  // R7 victim back
    };

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic do_miss(input logic [31:0] pa, input logic [31:0] va,
                           input bit exp_purge, input logic [8:0] exp_idx,
                           input logic [25:0] exp_line, input string req);
        @(negedge clk);
        chk(miss_ready == 1'b1, "R10", "ready before miss", 32'(miss_ready), 1);
        miss_valid = 1'b1;
        miss_pa    = pa;
        miss_va    = va;
        @(negedge clk);
        miss_valid = 1'b0;
        chk(miss_ready == 1'b0, "R10", "busy after accept", 32'(miss_ready), 0);
        chk(purge_req == exp_purge, req, "purge_req", 32'(purge_req), 32'(exp_purge));
        if (exp_purge) begin
            chk(purge_index == exp_idx, req, "purge_index", 32'(purge_index), 32'(exp_idx));
            chk(purge_line == exp_line, req, "purge_line", 32'(purge_line), 32'(exp_line));
            chk(fill_ok == 1'b0, "R5", "no grant during purge", 32'(fill_ok), 0);
            // R10: a new miss offered while busy must be ignored
            miss_valid = 1'b1;
            miss_va    = 32'h0000_6340;
            for (int k = 0; k < 2; k++) begin
                @(negedge clk);
                chk(purge_req == 1'b1, "R5", "purge held", 32'(purge_req), 1);
                chk(purge_index == exp_idx, "R5", "index held", 32'(purge_index), 32'(exp_idx));
                chk(fill_ok == 1'b0, "R5", "grant waits for ack", 32'(fill_ok), 0);
            end
            miss_valid = 1'b0;
            purge_ack  = 1'b1;
            @(negedge clk);
            purge_ack  = 1'b0;
            chk(fill_ok == 1'b1, "R5", "grant after ack", 32'(fill_ok), 1);
            chk(purge_req == 1'b0, "R5", "purge dropped", 32'(purge_req), 0);
        end else begin
            chk(fill_ok == 1'b1, "R2", "grant next cycle", 32'(fill_ok), 1);
        end
        chk(miss_ready == 1'b0, "R10", "busy in grant cycle", 32'(miss_ready), 0);
        @(negedge clk);
        chk(fill_ok == 1'b0, "R2", "grant one cycle", 32'(fill_ok), 0);
        chk(miss_ready == 1'b1, "R10", "idle after grant", 32'(miss_ready), 1);
        chk(purge_req == 1'b0, "R10", "ignored miss left no purge", 32'(purge_req), 0);
    endtask

    task automatic do_evict(input logic [25:0] line);
        @(negedge clk);
        evict_valid = 1'b1;
        evict_line  = line;
        @(negedge clk);
        evict_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        chk(miss_ready == 1'b1, "R1", "ready", 32'(miss_ready), 1);
        chk(purge_req == 1'b0, "R1", "purge_req", 32'(purge_req), 0);
        chk(fill_ok == 1'b0, "R1", "fill_ok", 32'(fill_ok), 0);

        for (int i = 0; i < NV; i++) begin
            do_miss(VEC[i][99:68], VEC[i][67:36], VEC[i][35], VEC[i][34:26],
                    VEC[i][25:0], $sformatf("vec%0d", i));
        end

        // R9: eviction of a line not resident in that slot is ignored
        do_evict(26'h000148D);
        do_miss(32'h0001_2340, 32'h0000_1340, 1'b1, 9'h0CD, 26'h000048D, "R9");

        // R8: eviction of the resident line clears it
        do_evict(26'h000048D);
        do_miss(32'h0001_2340, 32'h0000_5340, 1'b0, 9'h000, 26'h0000000, "R8");

        // R1: reset empties the directory
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        do_miss(32'h0001_2340, 32'h0000_1340, 1'b0, 9'h000, 26'h0000000, "R1");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog run did not complete actual=0 expected=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule